// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Word Error Flags

This block recovers asynchronous serial characters from a single input line. A free-running tick at sixteen times the bit rate paces it. A falling level on the idle line marks a candidate start bit. Each bit cell is then judged by a vote of three samples taken around its centre. The character is shifted in least significant bit first. Its length, parity mode and number of stop bits come from shared configuration inputs.

Every completed character is written into a small first-in first-out store, together with its own parity-error and framing-error flags. A reader sees the oldest entry on a 16-bit word port and removes it with a one-cycle pop strobe. A level output shows that unread data is waiting. A separate sticky flag records a character that arrived while the store was full. A line held low for a whole character period shows up as an all-zero word with the framing flag set. Software break handling can detect it there.

Top module: `uart_rx_core`

## Requirements
- R1: A one-cycle pulse on `cmd_rx_en` turns reception on and a pulse on `cmd_rx_dis` turns it off; if both pulse together, off wins. Turning reception off abandons any character in progress, and while off no word is ever stored.
- R2: In idle, a low line on a tick starts a character. If the start bit's vote is high, the event is treated as noise: nothing is stored and the receiver returns to idle.
- R3: Tick 0 is the tick that detects the start. Each bit value is the 2-of-3 majority of the line on ticks 7, 8 and 9 of that bit's 16-tick cell, so a disturbance covering only one of those ticks does not change the bit.
- R4: `cfg_bits` gives the data length (5 to 9, and 0 or values above 9 mean 9). Bits are received LSB first and placed in `rd_word[8:0]`. Data bits above the configured length, and `rd_word[13:9]`, read as zero.
- R5: `cfg_par` = 2'b10 selects even parity and 2'b11 odd parity; 2'b00 and 2'b01 mean no parity bit. A mismatching parity bit sets `rd_word[14]` for that word only.
- R6: `cfg_two_stop` = 1 expects two stop bits, otherwise one. If any expected stop bit is judged low, `rd_word[15]` is set for that word. The word is stored at the end of the last stop bit.
- R7: A line held low for a full character produces a word whose data bits are all zero and whose bit 15 is set.
- R8: The store keeps two words in arrival order. `rd_word` shows the oldest word, or all zeros when empty. `rx_avail` is high while at least one word is unread. `rd_pop` removes the oldest word, and a pop on an empty store changes nothing.
- R9: A character that completes while the store is full, with no pop in that cycle, is discarded and the stored words are kept. `rx_overflow` then goes high and stays high until `ovf_clr` is pulsed.
- R10: After reset, reception is off, the store is empty, `rd_word` is zero and `rx_overflow` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cmd_rx_en | input | 1 | Pulse: turn reception on |
| cmd_rx_dis | input | 1 | Pulse: turn reception off |
| cfg_bits | input | 4 | Data bits per character |
| cfg_par | input | 2 | Parity mode: 10 even, 11 odd, else none |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| rd_pop | input | 1 | Pulse: remove the oldest word |
| ovf_clr | input | 1 | Pulse: clear the overflow flag |
| rd_word | output | 16 | Oldest word: data [8:0], parity error [14], framing error [15] |
| rx_avail | output | 1 | Store holds unread data |
| rx_overflow | output | 1 | Sticky overflow flag |

## Verification
The bench sends characters with a single-tick glitch placed on the centre sample of a data bit. A design that sampled once, or on the wrong ticks, would return a flipped bit. A short low pulse on an idle line must not become a character; a receiver that skipped the start-bit check would store a stray word. A third stimulus fills the store and then sends one more character, which must be dropped. A design that overwrote the store would show the newest word in place of the oldest, and a design that lost pointer state on an empty pop would return the wrong next word. The line is also held low for a whole character, and reception is switched off in mid-character, to check that the receiver neither hangs nor stores a half-received frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam int RX_WORD_W   = 16;
   localparam int RX_PERR_BIT = 14;
   localparam int RX_FERR_BIT = 15;

   typedef enum logic [1:0] {
      PAR_NONE     = 2'b00,
      PAR_NONE_ALT = 2'b01,
      PAR_EVEN     = 2'b10,
      PAR_ODD      = 2'b11
   } par_mode_e;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_START,
      FS_DATA,
      FS_PAR,
      FS_STOP
   } frm_state_e;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
   parameter int OS_RATE     = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit VOTE        = 1'b1,
   localparam int CNT_W      = $clog2(OS_RATE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_line,
   input  logic             tick,
   input  logic [CNT_W-1:0] phase,
   output logic             line_s,
   output logic             bit_val
);
   localparam int MID = OS_RATE / 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("uart_rx_sampler: SYNC_STAGES must be at least 2");
   end
   if (OS_RATE < 8 || (OS_RATE & (OS_RATE - 1)) != 0) begin : g_bad_rate
      $error("uart_rx_sampler: OS_RATE must be a power of two, 8 or more");
   end

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
   end
   assign line_s = sync_q[SYNC_STAGES-1];

   if (VOTE) begin : g_vote
      logic [2:0] samp_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) samp_q <= '1;
         else if (tick) begin
            if (phase == CNT_W'(MID - 1)) samp_q[0] <= line_s;
            if (phase == CNT_W'(MID))     samp_q[1] <= line_s;
            if (phase == CNT_W'(MID + 1)) samp_q[2] <= line_s;
         end
      end
      assign bit_val = (samp_q[0] & samp_q[1]) | (samp_q[0] & samp_q[2]) |
                       (samp_q[1] & samp_q[2]);
   end else begin : g_single
      logic samp_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) samp_q <= 1'b1;
         else if (tick && phase == CNT_W'(MID)) samp_q <= line_s;
      end
      assign bit_val = samp_q;
   end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int DATA_W   = 9,
   parameter int OS_RATE  = 16,
   localparam int CNT_W   = $clog2(OS_RATE),
   localparam int BITS_W  = $clog2(DATA_W + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 tick,
   input  logic                 line_s,
   input  logic                 bit_val,
   input  logic [BITS_W-1:0]    cfg_bits,
   input  logic [1:0]           cfg_par,
   input  logic                 cfg_two_stop,
   output logic [CNT_W-1:0]     phase,
   output logic                 push,
   output logic [RX_WORD_W-1:0] push_word
);
   if (DATA_W < 1 || DATA_W > RX_PERR_BIT) begin : g_bad_width
      $error("uart_rx_frame: DATA_W must fit below the error flag bits");
   end

   frm_state_e          st_q;
   logic [CNT_W-1:0]    phase_q;
   logic [BITS_W-1:0]   bit_q;
   logic [DATA_W-1:0]   shreg_q;
   logic                par_q, perr_q, ferr_q, stop_q, push_q;

   par_mode_e           pmode;
   logic [BITS_W-1:0]   nb;
   logic                cell_end, last_data, last_stop, par_on;
   logic [DATA_W-1:0]   data_out;

   assign pmode     = par_mode_e'(cfg_par);
   assign par_on    = (pmode == PAR_EVEN) || (pmode == PAR_ODD);
   assign nb        = (cfg_bits == '0 || cfg_bits > BITS_W'(DATA_W)) ? BITS_W'(DATA_W) : cfg_bits;
   assign cell_end  = (phase_q == CNT_W'(OS_RATE - 1));
   assign last_data = (bit_q == nb - 1'b1);
   assign last_stop = !cfg_two_stop || stop_q;
   assign data_out  = shreg_q >> (BITS_W'(DATA_W) - nb);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= FS_IDLE;
         phase_q <= '0;
         bit_q   <= '0;
         shreg_q <= '0;
         par_q   <= 1'b0;
         perr_q  <= 1'b0;
         ferr_q  <= 1'b0;
         stop_q  <= 1'b0;
         push_q  <= 1'b0;
      end else begin
         push_q <= 1'b0;
         if (!en) begin
            st_q <= FS_IDLE;
         end else if (tick) begin
            if (st_q == FS_IDLE) begin
               if (!line_s) begin
                  st_q    <= FS_START;
                  phase_q <= CNT_W'(1);
                  bit_q   <= '0;
                  shreg_q <= '0;
                  par_q   <= 1'b0;
                  perr_q  <= 1'b0;
                  ferr_q  <= 1'b0;
                  stop_q  <= 1'b0;
               end
            end else begin
               phase_q <= phase_q + 1'b1;
               if (cell_end) begin
                  case (st_q)
                     FS_START: st_q <= bit_val ? FS_IDLE : FS_DATA;
                     FS_DATA: begin
                        shreg_q <= {bit_val, shreg_q[DATA_W-1:1]};
                        par_q   <= par_q ^ bit_val;
                        bit_q   <= bit_q + 1'b1;
                        if (last_data) st_q <= par_on ? FS_PAR : FS_STOP;
                     end
                     FS_PAR: begin
                        perr_q <= par_q ^ bit_val ^ (pmode == PAR_ODD);
                        st_q   <= FS_STOP;
                     end
                     FS_STOP: begin
                        if (!bit_val) ferr_q <= 1'b1;
                        if (last_stop) begin
                           push_q <= 1'b1;
                           st_q   <= FS_IDLE;
                        end else begin
                           stop_q <= 1'b1;
                        end
                     end
                     default: st_q <= FS_IDLE;
                  endcase
               end
            end
         end
      end
   end

   always_comb begin
      push_word               = '0;
      push_word[DATA_W-1:0]   = data_out;
      push_word[RX_PERR_BIT]  = perr_q;
      push_word[RX_FERR_BIT]  = ferr_q;
   end
   assign push  = push_q;
   assign phase = phase_q;

   AST_NOISY_START: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && st_q == FS_START && cell_end && bit_val) |=> (st_q == FS_IDLE && !push)); // R2
   AST_PUSH_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> ($past(st_q) == FS_STOP)); // R6
   AST_STOP_LOW_FERR: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && st_q == FS_STOP && cell_end && !bit_val) |=> push_word[RX_FERR_BIT]); // R6
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
   parameter int W      = 16,
   parameter int DEPTH  = 2,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_word,
   input  logic         pop,
   input  logic         ovf_clr,
   output logic [W-1:0] head,
   output logic         avail,
   output logic         ovf
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("uart_rx_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]     mem_q [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q, full, push_ok, pop_ok;

   function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign push_ok = push && (!full || pop);
   assign pop_ok  = pop && (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
         ovf_q <= 1'b0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else begin
         if (push_ok) begin
            mem_q[wr_q] <= push_word;
            wr_q        <= nxt(wr_q);
         end
         if (pop_ok) rd_q <= nxt(rd_q);
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: ;
         endcase
         if (push && !push_ok) ovf_q <= 1'b1;
         else if (ovf_clr)     ovf_q <= 1'b0;
      end
   end

   assign avail = (cnt_q != '0);
   assign head  = avail ? mem_q[rd_q] : '0;
   assign ovf   = ovf_q;

   AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && cnt_q != '0 && !push) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && cnt_q == '0 && !push) |=> (cnt_q == '0)); // R8
   AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (ovf && cnt_q == CNT_W'(DEPTH))); // R9
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf); // R9
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
   import uart_rx_pkg::*;
#(
   parameter int DATA_W      = 9,
   parameter int OS_RATE     = 16,
   parameter int RX_DEPTH    = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit VOTE        = 1'b1,
   localparam int BITS_W     = $clog2(DATA_W + 1),
   localparam int CNT_W      = $clog2(OS_RATE)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 os_tick,
   input  logic                 rx_line,
   input  logic                 cmd_rx_en,
   input  logic                 cmd_rx_dis,
   input  logic [BITS_W-1:0]    cfg_bits,
   input  logic [1:0]           cfg_par,
   input  logic                 cfg_two_stop,
   input  logic                 rd_pop,
   input  logic                 ovf_clr,
   output logic [RX_WORD_W-1:0] rd_word,
   output logic                 rx_avail,
   output logic                 rx_overflow
);
   logic                 rx_en_q, line_s, bit_val, frm_push;
   logic [CNT_W-1:0]     phase;
   logic [RX_WORD_W-1:0] frm_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rx_en_q <= 1'b0;
      else if (cmd_rx_dis) rx_en_q <= 1'b0;
      else if (cmd_rx_en)  rx_en_q <= 1'b1;
   end

   uart_rx_sampler #(.OS_RATE(OS_RATE), .SYNC_STAGES(SYNC_STAGES), .VOTE(VOTE)) u_samp (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick(os_tick), .phase(phase),
      .line_s(line_s), .bit_val(bit_val));

   uart_rx_frame #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_frm (
      .clk(clk), .rst_n(rst_n), .en(rx_en_q), .tick(os_tick), .line_s(line_s),
      .bit_val(bit_val), .cfg_bits(cfg_bits), .cfg_par(cfg_par),
      .cfg_two_stop(cfg_two_stop), .phase(phase), .push(frm_push), .push_word(frm_word));

   uart_rx_fifo #(.W(RX_WORD_W), .DEPTH(RX_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(frm_push), .push_word(frm_word), .pop(rd_pop),
      .ovf_clr(ovf_clr), .head(rd_word), .avail(rx_avail), .ovf(rx_overflow));

   AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en_q |=> !frm_push); // R1
endmodule

// File: tb/uart_rx_core_tb_top.sv
module uart_rx_core_tb_top;
   localparam int TICK_DIV = 4;
   localparam int BIT_CLKS = TICK_DIV * 16;
   localparam int NVEC     = 6;
   // {bits[3:0], par[1:0], two_stop, data[8:0], bad_par, bad_stop, expected[15:0]}
   localparam logic [33:0] VEC [NVEC] = '{
      {4'd8, 2'b00, 1'b0, 9'h0A5, 1'b0, 1'b0, 16'h00A5},
      {4'd7, 2'b10, 1'b0, 9'h035, 1'b0, 1'b0, 16'h0035},
      {4'd9, 2'b11, 1'b1, 9'h1C3, 1'b0, 1'b0, 16'h01C3},
      {4'd5, 2'b10, 1'b0, 9'h01F, 1'b1, 1'b0, 16'h401F},
      {4'd8, 2'b00, 1'b1, 9'h03C, 1'b0, 1'b1, 16'h803C},
      {4'd6, 2'b11, 1'b0, 9'h02A, 1'b0, 1'b0, 16'h002A}
   };

   logic        clk = 1'b0;
   logic        rst_n, os_tick, rx_line, cmd_rx_en, cmd_rx_dis;
   logic [3:0]  cfg_bits;
   logic [1:0]  cfg_par;
   logic        cfg_two_stop, rd_pop, ovf_clr;
   logic [15:0] rd_word;
   logic        rx_avail, rx_overflow;
   logic [1:0]  tdiv = 2'd0;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) tdiv <= tdiv + 2'd1;
   assign os_tick = (tdiv == 2'd3);

   uart_rx_core dut_i (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
      .cmd_rx_en(cmd_rx_en), .cmd_rx_dis(cmd_rx_dis), .cfg_bits(cfg_bits),
      .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop), .rd_pop(rd_pop),
      .ovf_clr(ovf_clr), .rd_word(rd_word), .rx_avail(rx_avail),
      .rx_overflow(rx_overflow));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int n);
      rx_line = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_pop();
      rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0; @(negedge clk);
   endtask

   task automatic pulse_en(input logic on);
      if (on) cmd_rx_en = 1'b1; else cmd_rx_dis = 1'b1;
      @(negedge clk);
      cmd_rx_en = 1'b0; cmd_rx_dis = 1'b0;
      @(negedge clk);
   endtask

   // bit index 0 is the start bit; gl selects a bit to carry a one-tick glitch
   task automatic send(input logic [8:0] d, input int nb, input logic [1:0] par,
                       input logic two, input logic badp, input logic bads, input int gl);
      logic       b [13];
      int         n;
      logic [8:0] md;
      logic       p;
      md = d & ((9'h1 << nb) - 9'h1);
      p  = ^md;
      if (par == 2'b11) p = ~p;
      if (badp) p = ~p;
      n = 0;
      b[n] = 1'b0; n++;
      for (int i = 0; i < nb; i++) begin b[n] = md[i]; n++; end
      if (par[1]) begin b[n] = p; n++; end
      b[n] = !bads; n++;
      if (two) begin b[n] = 1'b1; n++; end
      for (int k = 0; k < n; k++) begin
         if (k == gl) begin
            hold(b[k], 32); hold(~b[k], 4); hold(b[k], BIT_CLKS - 36);
         end else begin
            hold(b[k], BIT_CLKS);
         end
      end
      hold(1'b1, 24);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; rx_line = 1'b1; cmd_rx_en = 1'b0; cmd_rx_dis = 1'b0;
      cfg_bits = 4'd8; cfg_par = 2'b00; cfg_two_stop = 1'b0; rd_pop = 1'b0; ovf_clr = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      chk("R10 reset word", rd_word, 16'h0000);
      chk("R10 reset avail", {15'd0, rx_avail}, 16'h0000);
      chk("R10 reset overflow", {15'd0, rx_overflow}, 16'h0000);

      // R1: receiver starts off, nothing stored
      send(9'h077, 8, 2'b00, 1'b0, 1'b0, 1'b0, -1);
      chk("R1 off after reset", {15'd0, rx_avail}, 16'h0000);
      pulse_en(1'b1);

      // R4 R5 R6: vector walk
      for (int i = 0; i < NVEC; i++) begin
         logic [33:0] v;
         v = VEC[i];
         cfg_bits = v[33:30]; cfg_par = v[29:28]; cfg_two_stop = v[27];
         send(v[26:18], int'(v[33:30]), v[29:28], v[27], v[17], v[16], -1);
         chk("R4 R5 R6 vector word", rd_word, v[15:0]);
         chk("R8 avail after word", {15'd0, rx_avail}, 16'h0001);
         pulse_pop();
      end

      cfg_bits = 4'd8; cfg_par = 2'b00; cfg_two_stop = 1'b0;
      // R3: single-tick glitch on a data bit centre
      send(9'h0FF, 8, 2'b00, 1'b0, 1'b0, 1'b0, 3);
      chk("R3 low glitch", rd_word, 16'h00FF);
      pulse_pop();
      send(9'h000, 8, 2'b00, 1'b0, 1'b0, 1'b0, 5);
      chk("R3 high glitch", rd_word, 16'h0000);
      chk("R3 word stored", {15'd0, rx_avail}, 16'h0001);
      pulse_pop();

      // R2: short low pulse is noise
      hold(1'b0, 16); hold(1'b1, 1000);
      chk("R2 noise start", {15'd0, rx_avail}, 16'h0000);

      // R7: break
      hold(1'b0, 10 * BIT_CLKS); hold(1'b1, 200);
      chk("R7 break word", rd_word, 16'h8000);
      pulse_pop();
      chk("R7 single word", {15'd0, rx_avail}, 16'h0000);

      // R9 and R8: overflow then drain
      send(9'h011, 8, 2'b00, 1'b0, 1'b0, 1'b0, -1);
      send(9'h022, 8, 2'b00, 1'b0, 1'b0, 1'b0, -1);
      chk("R9 no overflow at two", {15'd0, rx_overflow}, 16'h0000);
      send(9'h033, 8, 2'b00, 1'b0, 1'b0, 1'b0, -1);
      chk("R9 overflow set", {15'd0, rx_overflow}, 16'h0001);
      chk("R9 oldest kept", rd_word, 16'h0011);
      pulse_pop();
      chk("R8 second word", rd_word, 16'h0022);
      pulse_pop();
      chk("R8 empty word zero", rd_word, 16'h0000);
      chk("R8 empty avail", {15'd0, rx_avail}, 16'h0000);
      pulse_pop();
      chk("R8 empty pop ignored", {15'd0, rx_avail}, 16'h0000);
      send(9'h044, 8, 2'b00, 1'b0, 1'b0, 1'b0, -1);
      chk("R8 order after empty pop", rd_word, 16'h0044);
      chk("R9 overflow sticky", {15'd0, rx_overflow}, 16'h0001);
      pulse_pop();
      ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; @(negedge clk);
      chk("R9 overflow cleared", {15'd0, rx_overflow}, 16'h0000);

      // R1: disable mid-character, then stays silent, then re-enable
      hold(1'b0, 200);
      cmd_rx_dis = 1'b1; @(negedge clk); cmd_rx_dis = 1'b0;
      hold(1'b1, 700);
      chk("R1 abort mid frame", {15'd0, rx_avail}, 16'h0000);
      send(9'h077, 8, 2'b00, 1'b0, 1'b0, 1'b0, -1);
      chk("R1 silent while off", {15'd0, rx_avail}, 16'h0000);
      cmd_rx_en = 1'b1; cmd_rx_dis = 1'b1; @(negedge clk);
      cmd_rx_en = 1'b0; cmd_rx_dis = 1'b0; @(negedge clk);
      send(9'h066, 8, 2'b00, 1'b0, 1'b0, 1'b0, -1);
      chk("R1 off wins", {15'd0, rx_avail}, 16'h0000);
      pulse_en(1'b1);
      send(9'h05A, 8, 2'b00, 1'b0, 1'b0, 1'b0, -1);
      chk("R1 back on", rd_word, 16'h005A);
      pulse_pop();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule